// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a one-shot alarm that counts down a number of seconds. Software writes the seconds remaining into a counter register and sets a run bit. Each pulse on the 1 Hz tick input then takes one from the count. When the count steps from one to zero, a sticky pending flag is raised. Software clears that flag by writing a one to it.

The pending flag drives two outputs, each with its own enable bit. One is an interrupt request. The other is a wake request that can bring the system out of a low-power state. Both outputs are registered.

Software reloads the counter with a fixed sequence: clear the run bit, write zero to the counter, wait, write the new count, then set the run bit again. All registers sit on a simple synchronous bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is returned on the edge after `bus_rd` is sampled.

Top module: `secs_alarm`

## Requirements
- R1: After reset, every register reads zero, and `irq_o` and `wake_o` are low.
- R2: A write to offset 0x20 loads the seconds counter. A read of offset 0x20 returns the seconds still remaining.
- R3: The counter drops by exactly one on a clock where `tick_i` is high, the run bit (offset 0x28, bit 0) is set, and the count is nonzero. On any clock without a tick, the count does not change.
- R4: A count of zero stays at zero when ticks arrive, and those ticks do not raise the pending flag.
- R5: The pending flag (offset 0x30, bit 0) is set on the tick that moves the count from 1 to 0.
- R6: Writing 1 to bit 0 of offset 0x30 clears the pending flag, and writing 0 leaves it alone. If an expiry and a clearing write land on the same clock, the flag ends up set.
- R7: One clock after the flag and the interrupt-enable bit (offset 0x2C, bit 0) change, `irq_o` equals the flag AND that enable bit.
- R8: One clock after the flag and the wake bit (offset 0x50, bit 0) change, `wake_o` equals the flag AND the wake bit.
- R9: Clearing the run bit freezes the count while ticks continue, and it does not change the pending flag.
- R10: A counter write on the same clock as a counting tick wins: the new count is the written value.
- R11: The control registers keep only bit 0, so their other bits read as zero. Any address that is not mapped reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the clock after `bus_rd` |
| tick_i | input | 1 | One-clock pulse, once per second |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
The countdown is driven several ways:
- Ticks with the run bit set, with it cleared, and with it set but no tick. These separate a counter that decrements per tick from one that is gated by the run bit or that counts clock cycles.
- Ticks applied at a count of zero. These show whether the counter wraps or raises a false expiry.
- A counter write and a tick on the same clock, and a clearing write and an expiry on the same clock. These pin down which event takes priority.
- Every combination of the interrupt-enable and wake bits against a set flag. This separates the two output masks from each other.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  // Register byte offsets; software depends on these positions.
  localparam int OFS_COUNT = 'h20;
  localparam int OFS_RUN   = 'h28;
  localparam int OFS_IRQEN = 'h2C;
  localparam int OFS_FLAG  = 'h30;
  localparam int OFS_WAKE  = 'h50;

  typedef struct packed {
    logic run;
    logic irq_en;
    logic wake_en;
  } alarm_ctl_t;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              pend,
  output alarm_ctl_t        ctl,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr_o,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(OFS_RUN);
  localparam logic [ADDR_W-1:0] A_IRQEN = ADDR_W'(OFS_IRQEN);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_WAKE  = ADDR_W'(OFS_WAKE);

  alarm_ctl_t        ctl_q;
  logic [DATA_W-1:0] rd_mux;

  assign ctl      = ctl_q;
  assign load_o   = bus_wr && (bus_addr == A_COUNT);
  assign load_val = bus_wdata[CNT_W-1:0];
  assign clr_o    = bus_wr && (bus_addr == A_FLAG) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_RUN)   ctl_q.run     <= bus_wdata[0];
      if (bus_addr == A_IRQEN) ctl_q.irq_en  <= bus_wdata[0];
      if (bus_addr == A_WAKE)  ctl_q.wake_en <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_COUNT: rd_mux = DATA_W'(cnt_val);
      A_RUN:   rd_mux = DATA_W'(ctl_q.run);
      A_IRQEN: rd_mux = DATA_W'(ctl_q.irq_en);
      A_FLAG:  rd_mux = DATA_W'(pend);
      A_WAKE:  rd_mux = DATA_W'(ctl_q.wake_en);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/alarm_counter.sv
module alarm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = run && tick && !load && (cnt_q != '0);
  assign expire_o = step && (cnt_q == ONE);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/alarm_event.sv
module alarm_event (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr,
  input  logic irq_en,
  input  logic wake_en,
  output logic pend_o,
  output logic irq_o,
  output logic wake_o
);
  logic pend_q;

  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      // A new expiry outranks a clearing write on the same clock.
      if (expire)   pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
      irq_o  <= pend_q && irq_en;
      wake_o <= pend_q && wake_en;
    end
  end
endmodule

// File: rtl/secs_alarm.sv
module secs_alarm
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_i,
  output logic              irq_o,
  output logic              wake_o
);
  alarm_ctl_t       ctl;
  logic             run_en, irq_en, wake_en;
  logic             load, clr, expire, pend;
  logic [CNT_W-1:0] load_val, cnt;

  assign run_en  = ctl.run;
  assign irq_en  = ctl.irq_en;
  assign wake_en = ctl.wake_en;

  alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt), .pend(pend),
    .ctl(ctl), .load_o(load), .load_val(load_val), .clr_o(clr),
    .bus_rdata(bus_rdata)
  );

  alarm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_en), .tick(tick_i), .load(load),
    .load_val(load_val), .cnt_o(cnt), .expire_o(expire)
  );

  alarm_event u_evt (
    .clk(clk), .rst(rst), .expire(expire), .clr(clr), .irq_en(irq_en),
    .wake_en(wake_en), .pend_o(pend), .irq_o(irq_o), .wake_o(wake_o)
  );
endmodule

// File: rtl/secs_alarm_chk.sv
module secs_alarm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run,
  input logic             load,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic             clr,
  input logic             irq_en,
  input logic             wake_en,
  input logic             irq_o,
  input logic             wake_o
);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !load && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt));

  assert_zero_floor_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> (cnt == '0));

  assert_expire_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !load && cnt == CNT_W'(1)) |=> pend);

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);

  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(pend && irq_en)));

  assert_wake_mask_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wake_o == $past(pend && wake_en)));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt));
endmodule

bind secs_alarm secs_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_i), .run(run_en), .load(load), .cnt(cnt),
  .pend(pend), .clr(clr), .irq_en(irq_en), .wake_en(wake_en),
  .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/secs_alarm_tb.sv
module secs_alarm_tb;
  localparam logic [7:0] A_CNT  = 8'h20;
  localparam logic [7:0] A_RUN  = 8'h28;
  localparam logic [7:0] A_IE   = 8'h2C;
  localparam logic [7:0] A_FLAG = 8'h30;
  localparam logic [7:0] A_WAKE = 8'h50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tick_i = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wake_o;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  secs_alarm u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_i(tick_i), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic arm(input logic [31:0] secs);
    wr(A_RUN, 0); wr(A_CNT, 0); repeat (3) @(negedge clk);
    wr(A_CNT, secs); wr(A_RUN, 1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_RUN, v);  check("R1 run", v, 0);
    rd(A_IE, v);   check("R1 irq_en", v, 0);
    rd(A_FLAG, v); check("R1 flag", v, 0);
    rd(A_WAKE, v); check("R1 wake cfg", v, 0);
    check("R1 irq_o", {31'b0, irq_o}, 0);
    check("R1 wake_o", {31'b0, wake_o}, 0);
  endtask

  task automatic t_load_count();
    logic [31:0] v;
    wr(A_CNT, 32'd5);
    rd(A_CNT, v); check("R2 load", v, 5);
    ticks(2);
    rd(A_CNT, v); check("R9 no run no count", v, 5);
    wr(A_RUN, 1);
    ticks(3);
    rd(A_CNT, v); check("R3 three ticks", v, 2);
    repeat (10) @(negedge clk);
    rd(A_CNT, v); check("R3 idle clocks", v, 2);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    wr(A_IE, 1); wr(A_WAKE, 1);
    ticks(1);
    rd(A_FLAG, v); check("R5 not yet", v, 0);
    ticks(1);
    rd(A_FLAG, v); check("R5 flag set", v, 1);
    check("R7 irq high", {31'b0, irq_o}, 1);
    check("R8 wake high", {31'b0, wake_o}, 1);
    ticks(3);
    rd(A_CNT, v); check("R4 floor", v, 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(A_FLAG, 0);
    rd(A_FLAG, v); check("R6 write zero", v, 1);
    wr(A_FLAG, 1);
    rd(A_FLAG, v); check("R6 w1c", v, 0);
    check("R7 irq low", {31'b0, irq_o}, 0);
    check("R8 wake low", {31'b0, wake_o}, 0);
    ticks(2);
    rd(A_FLAG, v); check("R4 no false expiry", v, 0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(A_IE, 0); wr(A_WAKE, 0);
    arm(1); ticks(1);
    rd(A_FLAG, v); check("R5 one second", v, 1);
    check("R7 masked", {31'b0, irq_o}, 0);
    check("R8 masked", {31'b0, wake_o}, 0);
    wr(A_IE, 1); @(negedge clk);
    check("R7 irq only", {31'b0, irq_o}, 1);
    check("R8 wake still low", {31'b0, wake_o}, 0);
    wr(A_IE, 0); wr(A_WAKE, 1); @(negedge clk);
    check("R7 irq off", {31'b0, irq_o}, 0);
    check("R8 wake only", {31'b0, wake_o}, 1);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    arm(3); ticks(1);
    wr(A_RUN, 0); ticks(2);
    rd(A_CNT, v);  check("R9 frozen", v, 2);
    rd(A_FLAG, v); check("R9 flag kept", v, 1);
    wr(A_FLAG, 1);
  endtask

  task automatic t_races();
    logic [31:0] v;
    arm(3);
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 7; tick_i = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick_i = 1'b0;
    rd(A_CNT, v); check("R10 load wins", v, 7);
    arm(1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 1; tick_i = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick_i = 1'b0;
    rd(A_FLAG, v); check("R6 set beats clear", v, 1);
    wr(A_FLAG, 1);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(A_IE, 32'hFFFF_FFFF);
    rd(A_IE, v); check("R11 bit0 only", v, 1);
    wr(8'h40, 32'h1234_5678);
    rd(8'h40, v); check("R11 unmapped", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_count();
    t_expire();
    t_clear();
    t_masks();
    t_disable();
    t_races();
    t_fields();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule